// File: doc/BRIEF.md
# Ternary Recirculating-Loop Trit Store

This block holds a single balanced-ternary digit (a trit) in a loop of four register zones. A shared phase counter moves through the zones, and each phase tick moves the stored trit forward by one zone. One trip around the loop takes four ticks, which is one full cycle. The value is written back into the loop through two ternary gates. First, an inner minimum gate combines the negated control trit with the value returning from the last zone. Second, an outer maximum gate combines that result with the data trit. So the next stored value is max(x, min(-w, q)).

The control trit selects the operation. With control at +1 the inner gate gives -1, and the data trit is loaded. With control at -1 and data held at -1 the loop keeps its content, so a read is the same as a hold. Any other input combination is reported on an error flag while the input window is open. Those combinations are still evaluated by the same formula. A register several trits wide is made by placing copies of this block side by side. The ternary gates can be built in two ways, chosen by a parameter: as majority voters with one input tied, or as direct min/max.

Top module: `tern_loop_cell`

## Requirements
- R1: Trits use 2-bit codes: 2'b11 is -1, 2'b00 is 0 and 2'b01 is +1. The code 2'b10 is illegal on any input and is evaluated as 0. The output q only ever shows one of the three legal codes.
- R2: While reset is active and straight after it, q is 2'b00, q_valid is 0 and the phase is 0.
- R3: Each clock with phase_tick high moves the phase one step through 0,1,2,3 and back to 0. A clock without phase_tick changes neither the phase nor q.
- R4: The inputs are sampled only at the tick taken while the phase is 0. Inputs present at any other tick, or between ticks, have no effect on q.
- R5: A cycle with control -1 and data -1 leaves the stored trit unchanged. This is a read.
- R6: A cycle with control +1 stores the data trit, for each of -1, 0 and +1.
- R7: For every input combination the stored trit becomes max(x, min(-w, q)). This includes control -1 with data 0 or +1.
- R8: A trit sampled at a phase-0 tick appears on q at the phase-3 tick. That is four ticks after the tick that opened the phase-0 window. q then holds that trit until the next phase-3 tick.
- R9: q_valid goes high at the first phase-3 tick after reset and stays high from then on.
- R10: err is high while the phase is 0 exactly when the control is not a legal -1 or +1, or the data is 2'b10, or the control is -1 and the data is not -1. err is low in every other phase.
- R11: The majority-gate build (GATE_STYLE 0) and the direct min/max build (GATE_STYLE 1) give identical q, q_valid and err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_tick | input | 1 | Moves the loop forward by one zone |
| ctrl_w | input | 2 | Control trit: +1 writes, -1 reads |
| data_x | input | 2 | Data trit to be stored |
| q | output | 2 | Stored trit, from the last zone |
| q_valid | output | 1 | q holds a value that has made a full loop |
| err | output | 1 | Illegal input combination in the phase-0 window |

## Verification
On every cycle, the assertions check the following. The phase steps correctly on each tick. Zone 0 captures nothing outside the phase-0 tick. A read puts the returning trit back into zone 0, and a write puts the data trit there. q stays stable between phase-3 ticks, only ever shows a legal code, and q_valid never falls. Other behaviour needs whole cycles of stimulus, so only the bench scenarios show it. That covers the end-to-end latency of four ticks, the full update formula across all legal combinations, the error flag's exact conditions and window, and the match between the two gate builds.

// File: rtl/tern_pkg.sv
package tern_pkg;
   typedef logic [1:0] trit_t;

   localparam trit_t T_NEG  = 2'b11;
   localparam trit_t T_ZERO = 2'b00;
   localparam trit_t T_POS  = 2'b01;
   localparam trit_t T_BAD  = 2'b10;

   // map the illegal code onto zero
   function automatic trit_t t_clean(input trit_t a);
      return (a == T_BAD) ? T_ZERO : a;
   endfunction

   function automatic trit_t t_neg(input trit_t a);
      return (a == T_POS) ? T_NEG : ((a == T_NEG) ? T_POS : T_ZERO);
   endfunction

   function automatic trit_t t_min(input trit_t a, input trit_t b);
      return ($signed(a) < $signed(b)) ? a : b;
   endfunction

   function automatic trit_t t_max(input trit_t a, input trit_t b);
      return ($signed(a) > $signed(b)) ? a : b;
   endfunction

   // three-input median, i.e. ternary majority
   function automatic trit_t t_maj(input trit_t a, input trit_t b, input trit_t c);
      return t_max(t_max(t_min(a, b), t_min(b, c)), t_min(a, c));
   endfunction
endpackage

// File: rtl/tern_phase_ctr.sv
module tern_phase_ctr
   import tern_pkg::*;
#(
   parameter int ZONES = 4,
   localparam int PH_W = (ZONES > 1) ? $clog2(ZONES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [PH_W-1:0]  ph,
   output logic [ZONES-1:0] zone_en
);
   localparam logic [PH_W-1:0] LAST = PH_W'(ZONES - 1);

   if (ZONES < 2) begin : g_bad_zones
      $error("tern_phase_ctr: ZONES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= '0;
      else if (tick)
         ph <= (ph == LAST) ? '0 : ph + 1'b1;
   end

   for (genvar k = 0; k < ZONES; k++) begin : g_en
      assign zone_en[k] = tick && (ph == PH_W'(k));
   end

   // R3
   ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ph == (($past(ph) == LAST) ? '0 : $past(ph) + 1'b1));

   // R3
   ph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(ph));
endmodule

// File: rtl/tern_gate.sv
module tern_gate
   import tern_pkg::*;
#(
   parameter int GATE_STYLE = 0
) (
   input  trit_t w,
   input  trit_t x,
   input  trit_t q,
   output trit_t nxt
);
   trit_t wc, xc, qc;

   assign wc = t_clean(w);
   assign xc = t_clean(x);
   assign qc = t_clean(q);

   if (GATE_STYLE == 0) begin : g_majority
      trit_t inner;
      // tying one input to -1 makes a majority gate compute min;
      // tying one input to +1 makes it compute max
      assign inner = t_maj(t_neg(wc), T_NEG, qc);
      assign nxt   = t_maj(xc, T_POS, inner);
   end else if (GATE_STYLE == 1) begin : g_direct
      assign nxt = t_max(xc, t_min(t_neg(wc), qc));
   end else begin : g_bad_style
      $error("tern_gate: GATE_STYLE must be 0 or 1");
      assign nxt = T_ZERO;
   end
endmodule

// File: rtl/tern_in_check.sv
module tern_in_check
   import tern_pkg::*;
(
   input  logic  window,
   input  trit_t w,
   input  trit_t x,
   output logic  err
);
   logic bad_ctrl, bad_data, dirty_read;

   assign bad_ctrl   = (w != T_NEG) && (w != T_POS);
   assign bad_data   = (x == T_BAD);
   assign dirty_read = (w == T_NEG) && (x != T_NEG);
   assign err        = window && (bad_ctrl || bad_data || dirty_read);
endmodule

// File: rtl/tern_loop_cell.sv
module tern_loop_cell
   import tern_pkg::*;
#(
   parameter int ZONES      = 4,
   parameter int GATE_STYLE = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       phase_tick,
   input  logic [1:0] ctrl_w,
   input  logic [1:0] data_x,
   output logic [1:0] q,
   output logic       q_valid,
   output logic       err
);
   localparam int PH_W = (ZONES > 1) ? $clog2(ZONES) : 1;

   if (ZONES < 2) begin : g_bad_zones
      $error("tern_loop_cell: ZONES must be at least 2");
   end

   logic [PH_W-1:0]  ph;
   logic [ZONES-1:0] zone_en;
   trit_t            gate_nxt;
   trit_t            stage_q [ZONES];

   tern_phase_ctr #(.ZONES(ZONES)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (phase_tick),
      .ph      (ph),
      .zone_en (zone_en)
   );

   tern_gate #(.GATE_STYLE(GATE_STYLE)) u_gate (
      .w   (ctrl_w),
      .x   (data_x),
      .q   (stage_q[ZONES-1]),
      .nxt (gate_nxt)
   );

   tern_in_check u_chk (
      .window (ph == '0),
      .w      (ctrl_w),
      .x      (data_x),
      .err    (err)
   );

   for (genvar k = 0; k < ZONES; k++) begin : g_zone
      trit_t d;
      trit_t zone_r;
      if (k == 0) begin : g_head
         assign d = gate_nxt;
      end else begin : g_body
         assign d = stage_q[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            zone_r <= T_ZERO;
         else if (zone_en[k])
            zone_r <= d;
      end
      assign stage_q[k] = zone_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_valid <= 1'b0;
      else if (zone_en[ZONES-1])
         q_valid <= 1'b1;
   end

   assign q = stage_q[ZONES-1];

   // R5
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zone_en[0] && ctrl_w == T_NEG && data_x == T_NEG) |=> stage_q[0] == $past(q));

   // R6
   write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zone_en[0] && ctrl_w == T_POS && data_x != T_BAD) |=> stage_q[0] == $past(data_x));

   // R4
   no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !zone_en[0] |=> $stable(stage_q[0]));

   // R8
   q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !zone_en[ZONES-1] |=> $stable(q));

   // R1
   q_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q != T_BAD);

   // R9
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> q_valid);
endmodule

// File: tb/tern_loop_cell_tb.sv
module tern_loop_cell_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] w_in = 2'b11;
   logic [1:0] x_in = 2'b11;
   logic [1:0] q_a, q_b;
   logic       v_a, v_b, e_a, e_b;

   int n_chk = 0;
   int n_fail = 0;
   int mdl_ph = 0;
   logic [1:0] mdl_cap = 2'b00;
   logic [1:0] mdl_q = 2'b00;
   logic       mdl_valid = 1'b0;
   int unused_seed;

   always #5 clk = ~clk;

   tern_loop_cell #(.ZONES(4), .GATE_STYLE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .phase_tick(tick), .ctrl_w(w_in), .data_x(x_in),
      .q(q_a), .q_valid(v_a), .err(e_a));

   tern_loop_cell #(.ZONES(4), .GATE_STYLE(1)) u_alt (
      .clk(clk), .rst_n(rst_n), .phase_tick(tick), .ctrl_w(w_in), .data_x(x_in),
      .q(q_b), .q_valid(v_b), .err(e_b));

   function automatic int tv(input logic [1:0] c);
      if (c == 2'b11) return -1;
      if (c == 2'b01) return 1;
      return 0;
   endfunction

   function automatic logic [1:0] tc(input int v);
      if (v < 0) return 2'b11;
      if (v > 0) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [1:0] ref_next(input logic [1:0] w, input logic [1:0] x,
                                           input logic [1:0] qv);
      int nw, inner, res;
      nw    = -tv(w);
      inner = (nw < tv(qv)) ? nw : tv(qv);
      res   = (tv(x) > inner) ? tv(x) : inner;
      return tc(res);
   endfunction

   function automatic logic ref_err(input logic [1:0] w, input logic [1:0] x);
      return (w != 2'b11 && w != 2'b01) || (x == 2'b10) || (w == 2'b11 && x != 2'b11);
   endfunction

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one full loop cycle: four ticks, inputs w/x presented in the phase-0 window
   task automatic run_cycle(input logic [1:0] w, input logic [1:0] x);
      for (int t = 0; t < 4; t++) begin
         if (mdl_ph == 0) begin
            w_in = w;
            x_in = x;
            #1;
            chk("R10 err in window", {1'b0, e_a}, {1'b0, ref_err(w, x)});
         end else begin
            w_in = 2'($urandom % 4);
            x_in = 2'($urandom % 4);
            #1;
            chk("R10 err outside window", {1'b0, e_a}, 2'b00);
         end
         chk("R11 err match", {1'b0, e_b}, {1'b0, e_a});
         tick = 1'b1;
         @(posedge clk);
         if (mdl_ph == 0) mdl_cap = ref_next(w_in, x_in, mdl_q);
         if (mdl_ph == 3) begin
            mdl_q = mdl_cap;
            mdl_valid = 1'b1;
         end
         mdl_ph = (mdl_ph + 1) % 4;
         @(negedge clk);
         tick = 1'b0;
         chk("R8 R7 q after tick", q_a, mdl_q);
         chk("R9 q_valid", {1'b0, v_a}, {1'b0, mdl_valid});
         chk("R11 q match", q_b, q_a);
         chk("R11 valid match", {1'b0, v_b}, {1'b0, v_a});
         // idle clock with junk inputs: nothing may move (R3, R4)
         w_in = 2'($urandom % 4);
         x_in = 2'($urandom % 4);
         @(negedge clk);
         chk("R3 q stable without tick", q_a, mdl_q);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      unused_seed = $urandom(32'h7A3C_19E5);
      repeat (3) @(negedge clk);
      chk("R2 q in reset", q_a, 2'b00);
      chk("R2 q_valid in reset", {1'b0, v_a}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 q after reset", q_a, 2'b00);
      chk("R2 q_valid after reset", {1'b0, v_a}, 2'b00);

      // directed sequence: read, w-1, w-1, read, w1, read, w0, w1, read, w0, read, read
      run_cycle(2'b11, 2'b11);
      run_cycle(2'b01, 2'b11);
      run_cycle(2'b01, 2'b11);
      run_cycle(2'b11, 2'b11);   // R5 read keeps -1
      run_cycle(2'b01, 2'b01);   // R6
      run_cycle(2'b11, 2'b11);
      run_cycle(2'b01, 2'b00);   // R6 write zero
      run_cycle(2'b01, 2'b01);
      run_cycle(2'b11, 2'b11);
      run_cycle(2'b01, 2'b00);
      run_cycle(2'b11, 2'b11);
      run_cycle(2'b11, 2'b11);

      // R7 corner: control -1 with data 0 over stored +1 and stored -1
      run_cycle(2'b01, 2'b01);
      run_cycle(2'b11, 2'b00);   // max(0, +1) = +1
      run_cycle(2'b01, 2'b11);
      run_cycle(2'b11, 2'b00);   // max(0, -1) = 0
      run_cycle(2'b11, 2'b01);   // max(+1, 0) = +1

      // R1 R10 illegal codes evaluated as 0
      run_cycle(2'b10, 2'b01);
      run_cycle(2'b00, 2'b11);
      run_cycle(2'b01, 2'b10);
      run_cycle(2'b10, 2'b11);

      // constrained random: mostly legal controls, any data
      for (int i = 0; i < 150; i++) begin
         logic [1:0] rw, rx;
         rw = ($urandom % 2 == 0) ? 2'b01 : 2'b11;
         case ($urandom % 3)
            0: rx = 2'b11;
            1: rx = 2'b00;
            default: rx = 2'b01;
         endcase
         if (rw == 2'b11 && ($urandom % 4 != 0)) rx = 2'b11;
         run_cycle(rw, rx);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule